// File: doc/BRIEF.md
# Packed Mixed-Sign Byte Multiply-Add Unit

This block is a SIMD datapath stage. Each byte of operand A is read as an unsigned number and multiplied by the byte in the same position of operand B, which is read as a signed two's-complement number. The two products from each adjacent pair of byte lanes are added. Each pair sum is clamped to the signed 16-bit range and becomes one output word.

The vector width is chosen per operation and can be 64, 128, 256 or 512 bits. Words beyond the chosen width are forced to zero. A per-word write mask can be switched on. When it is on, each word whose mask bit is clear either keeps the caller's old destination word (merge) or is cleared (zeroing). The result is registered, with a matching valid output one cycle after the input strobe. A per-word saturation flag reports where clamping happened.

Top module: `mixmac_top`

## Requirements
- R1: Byte lane k computes `A[8k+7:8k]` (unsigned, 0 to 255) times `B[8k+7:8k]` (signed, -128 to 127).
- R2: Output word i, at `result[16i+15:16i]`, is the sum of the products of byte lanes 2i and 2i+1. The sum is formed without wraparound before clamping, so an all-zero A gives 0 in every active word.
- R3: A pair sum above 32767 gives 0x7FFF, and a pair sum below -32768 gives 0x8000.
- R4: `sat_flags[i]` is 1 exactly when word i lies inside the selected width and its pair sum was clamped. The mask does not affect it.
- R5: `width_sel` uses the encoding 0 = 64 bits (4 words), 1 = 128 bits (8 words), 2 = 256 bits (16 words) and 3 = 512 bits (32 words). Words at or above the active count are 0, whatever the mask and old value.
- R6: With `mask_en` = 0, every active word takes its computed value, whatever `wmask` holds.
- R7: With `mask_en` = 1, `zero_mode` = 0 and `wmask[i]` = 0, active word i takes `old_dst[16i+15:16i]`.
- R8: With `mask_en` = 1, `zero_mode` = 1 and `wmask[i]` = 0, active word i is 0.
- R9: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `result` and `sat_flags` carry that operation's values in the same cycle.
- R10: In a cycle with `in_valid` low, `result` and `sat_flags` keep their values, even if the other inputs change.
- R11: While reset is held, and after it until the first operation, `out_valid`, `result` and `sat_flags` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| width_sel | input | 2 | Vector width code |
| opa | input | 512 | Unsigned byte operand |
| opb | input | 512 | Signed byte operand |
| old_dst | input | 512 | Prior destination value used for merging |
| wmask | input | 32 | Per-word write enable |
| mask_en | input | 1 | Apply wmask when 1 |
| zero_mode | input | 1 | 1 clears unmasked words, 0 merges them |
| out_valid | output | 1 | Result valid |
| result | output | 512 | Packed saturated words |
| sat_flags | output | 32 | Per-word clamp indicator |

## Verification
The clocked assertions assume that `in_valid`, `width_sel` and the operands are steady across each rising edge and are never X after reset. The bench drives every input on the falling edge only, so this assumption always holds. The combinational assertions on clamp extremes and zeroing assume nothing beyond defined values. Stimulus mixes random bytes with the all-0xFF by 0x7F and 0x80 extremes and a zero A operand. It covers every width code and all three mask modes, and inserts idle cycles with changing inputs so that the hold behaviour is exercised.

// File: rtl/mixmac_pkg.sv
package mixmac_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int PROD_W = 17;
  localparam int SUM_W  = 18;
  localparam int SEL_W  = 2;
  localparam int MIN_WORDS = 4;

  localparam logic signed [SUM_W-1:0] SUM_HI = SUM_W'(32767);
  localparam logic signed [SUM_W-1:0] SUM_LO = -SUM_W'(32768);
  localparam logic [WORD_W-1:0] WORD_MAX = 16'h7FFF;
  localparam logic [WORD_W-1:0] WORD_MIN = 16'h8000;

  // unsigned byte times signed byte, exact in PROD_W bits
  function automatic logic signed [PROD_W-1:0] mul_us(input logic [BYTE_W-1:0] u,
                                                      input logic [BYTE_W-1:0] s);
    logic signed [PROD_W-1:0] uu;
    logic signed [PROD_W-1:0] ss;
    uu = $signed({{(PROD_W-BYTE_W){1'b0}}, u});
    ss = $signed({{(PROD_W-BYTE_W){s[BYTE_W-1]}}, s});
    return uu * ss;
  endfunction

  function automatic logic signed [SUM_W-1:0] widen(input logic signed [PROD_W-1:0] p);
    return $signed({{(SUM_W-PROD_W){p[PROD_W-1]}}, p});
  endfunction

  function automatic logic clamp_hi(input logic signed [SUM_W-1:0] s);
    return s > SUM_HI;
  endfunction

  function automatic logic clamp_lo(input logic signed [SUM_W-1:0] s);
    return s < SUM_LO;
  endfunction

  function automatic logic [WORD_W-1:0] saturate(input logic signed [SUM_W-1:0] s);
    if (clamp_hi(s)) return WORD_MAX;
    if (clamp_lo(s)) return WORD_MIN;
    return s[WORD_W-1:0];
  endfunction

  // number of active words for a width code
  function automatic int unsigned words_for(input logic [SEL_W-1:0] sel);
    return MIN_WORDS << sel;
  endfunction
endpackage

// File: rtl/mixmac_lane.sv
module mixmac_lane
  import mixmac_pkg::*;
(
  input  logic [2*BYTE_W-1:0] a_pair,
  input  logic [2*BYTE_W-1:0] b_pair,
  output logic [WORD_W-1:0]   word,
  output logic                clamped
);
  logic signed [PROD_W-1:0] prod_lo;
  logic signed [PROD_W-1:0] prod_hi;
  logic signed [SUM_W-1:0]  pair_sum;
  logic                     ovf_hi;
  logic                     ovf_lo;

  always_comb begin
    prod_lo  = mul_us(a_pair[BYTE_W-1:0], b_pair[BYTE_W-1:0]);
    prod_hi  = mul_us(a_pair[2*BYTE_W-1:BYTE_W], b_pair[2*BYTE_W-1:BYTE_W]);
    pair_sum = widen(prod_lo) + widen(prod_hi);
    ovf_hi   = clamp_hi(pair_sum);
    ovf_lo   = clamp_lo(pair_sum);
    word     = saturate(pair_sum);
    clamped  = ovf_hi | ovf_lo;
  end

  always_comb begin
    if (clamped)
      AST_CLAMP_EXTREME: assert (word == WORD_MAX || word == WORD_MIN) else $error("clamp value"); // R3
    if (ovf_hi)
      AST_CLAMP_POS: assert (!word[WORD_W-1]) else $error("positive clamp sign"); // R3
  end
endmodule

// File: rtl/mixmac_wsel.sv
module mixmac_wsel
  import mixmac_pkg::*;
(
  input  logic              active,
  input  logic              mask_en,
  input  logic              mbit,
  input  logic              zero_mode,
  input  logic [WORD_W-1:0] calc,
  input  logic [WORD_W-1:0] old_word,
  output logic [WORD_W-1:0] out_word
);
  logic blocked;

  always_comb begin
    blocked = mask_en & ~mbit;
    if (!active)
      out_word = '0;
    else if (!blocked)
      out_word = calc;
    else if (zero_mode)
      out_word = '0;
    else
      out_word = old_word;
  end

  always_comb begin
    if (active && mask_en && !mbit && zero_mode)
      AST_ZERO_BLOCKED: assert (out_word == '0) else $error("zeroing"); // R8
    if (!active)
      AST_IDLE_WORD: assert (out_word == '0) else $error("idle word"); // R5
  end
endmodule

// File: rtl/mixmac_top.sv
module mixmac_top
  import mixmac_pkg::*;
#(
  parameter int VEC_W = 512
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [SEL_W-1:0]      width_sel,
  input  logic [VEC_W-1:0]      opa,
  input  logic [VEC_W-1:0]      opb,
  input  logic [VEC_W-1:0]      old_dst,
  input  logic [VEC_W/WORD_W-1:0] wmask,
  input  logic                  mask_en,
  input  logic                  zero_mode,
  output logic                  out_valid,
  output logic [VEC_W-1:0]      result,
  output logic [VEC_W/WORD_W-1:0] sat_flags
);
  localparam int NWORD = VEC_W / WORD_W;

  logic [NWORD-1:0] active_w;
  logic [NWORD-1:0] idle_w;
  logic [VEC_W-1:0] idle_bits;
  logic [NWORD-1:0] lane_clamp;
  logic [VEC_W-1:0] lane_word;
  logic [VEC_W-1:0] next_res;
  logic [NWORD-1:0] next_flags;

  logic             valid_q;
  logic [VEC_W-1:0] result_q;
  logic [NWORD-1:0] flags_q;

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    assign active_w[w] = 32'(w) < words_for(width_sel);
    assign idle_w[w]   = ~active_w[w];
    assign idle_bits[w*WORD_W +: WORD_W] = {WORD_W{idle_w[w]}};

    mixmac_lane u_lane (
      .a_pair (opa[w*WORD_W +: WORD_W]),
      .b_pair (opb[w*WORD_W +: WORD_W]),
      .word   (lane_word[w*WORD_W +: WORD_W]),
      .clamped(lane_clamp[w])
    );

    mixmac_wsel u_wsel (
      .active   (active_w[w]),
      .mask_en  (mask_en),
      .mbit     (wmask[w]),
      .zero_mode(zero_mode),
      .calc     (lane_word[w*WORD_W +: WORD_W]),
      .old_word (old_dst[w*WORD_W +: WORD_W]),
      .out_word (next_res[w*WORD_W +: WORD_W])
    );

    assign next_flags[w] = lane_clamp[w] & active_w[w];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
      flags_q  <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        result_q <= next_res;
        flags_q  <= next_flags;
      end
    end
  end

  assign out_valid = valid_q;
  assign result    = result_q;
  assign sat_flags = flags_q;

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid) else $error("valid latency"); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid) else $error("spurious valid"); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> ($stable(result) && $stable(sat_flags))) else $error("hold"); // R10
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> ((result & $past(idle_bits)) == '0)) else $error("upper words"); // R5
  AST_FLAG_UPPER: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> ((sat_flags & $past(idle_w)) == '0)) else $error("upper flags"); // R4
endmodule

// File: tb/tb_mixmac_top.sv
module tb_mixmac_top;
  localparam int VW = 512;
  localparam int NW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [1:0]    width_sel = '0;
  logic [VW-1:0] opa = '0, opb = '0, old_dst = '0;
  logic [NW-1:0] wmask = '0;
  logic          mask_en = 1'b0, zero_mode = 1'b0;
  logic          out_valid;
  logic [VW-1:0] result;
  logic [NW-1:0] sat_flags;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  logic [VW-1:0] exp_res = '0;
  logic [NW-1:0] exp_flags = '0;
  logic          exp_valid = 1'b0;
  string         pend = "R11 reset";

  always #2 clk = ~clk;

  mixmac_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .width_sel(width_sel),
    .opa(opa), .opb(opb), .old_dst(old_dst), .wmask(wmask),
    .mask_en(mask_en), .zero_mode(zero_mode),
    .out_valid(out_valid), .result(result), .sat_flags(sat_flags)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  task automatic compare(string tag);
    n_checks += 3;
    if (out_valid !== exp_valid) begin
      n_fail++; $display("FAIL %s out_valid act=%0b exp=%0b", tag, out_valid, exp_valid);
    end
    if (result !== exp_res) begin
      n_fail++; $display("FAIL %s result act=%h exp=%h", tag, result, exp_res);
    end
    if (sat_flags !== exp_flags) begin
      n_fail++; $display("FAIL %s sat_flags act=%h exp=%h", tag, sat_flags, exp_flags);
    end
  endtask

  // Behavioural model with integer arithmetic
  task automatic model(input logic [VW-1:0] a, b, od, input logic [NW-1:0] m,
                       input logic me, zm, input logic [1:0] ws);
    int nact;
    nact = 4 * (1 << ws);
    for (int w = 0; w < NW; w++) begin
      int u0, u1, s0, s1, sum;
      logic [15:0] v;
      logic f;
      u0 = int'(a[16*w +: 8]);
      u1 = int'(a[16*w+8 +: 8]);
      s0 = int'($signed(b[16*w +: 8]));
      s1 = int'($signed(b[16*w+8 +: 8]));
      sum = u0 * s0 + u1 * s1;
      f = 1'b0;
      if (sum > 32767) begin v = 16'h7FFF; f = 1'b1; end
      else if (sum < -32768) begin v = 16'h8000; f = 1'b1; end
      else v = 16'(sum);
      if (w >= nact) begin v = '0; f = 1'b0; end
      else if (me && !m[w]) v = zm ? 16'h0 : od[16*w +: 16];
      exp_res[16*w +: 16] = v;
      exp_flags[w] = f;
    end
  endtask

  // one cycle: check last expectation, then drive new inputs
  task automatic step(string tag, input logic v, input logic [VW-1:0] a, b, od,
                      input logic [NW-1:0] m, input logic me, zm, input logic [1:0] ws);
    @(negedge clk);
    compare(pend);
    in_valid = v; opa = a; opb = b; old_dst = od; wmask = m;
    mask_en = me; zero_mode = zm; width_sel = ws;
    exp_valid = v;
    if (v) model(a, b, od, m, me, zm, ws);
    pend = tag;
  endtask

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] r;
    for (int i = 0; i < VW / 32; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [VW-1:0] fill(input logic [7:0] x);
    return {(VW/8){x}};
  endfunction

  initial begin
    #(4 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    // R11: outputs zero during and just after reset
    repeat (3) @(negedge clk);
    compare("R11 in reset");
    rst_n = 1'b1;
    step("R11 idle after reset", 1'b0, rnd_vec(), rnd_vec(), rnd_vec(), '1, 1'b0, 1'b0, 2'd3);
    // R3 saturation corners at full width
    step("R3 R4 0xFF*0x7F clamps high", 1'b1, fill(8'hFF), fill(8'h7F), rnd_vec(), '0, 1'b0, 1'b0, 2'd3);
    step("R3 R4 0xFF*0x80 clamps low", 1'b1, fill(8'hFF), fill(8'h80), rnd_vec(), '0, 1'b0, 1'b0, 2'd3);
    // R2 zero operand A
    step("R2 zero A gives zero", 1'b1, '0, rnd_vec(), rnd_vec(), '0, 1'b0, 1'b0, 2'd3);
    // R1 R2 unsigned/signed mix without clamp: 0xFF*0x7F + 0x01*0x80 = 32257
    step("R1 R2 mixed pair no clamp", 1'b1, {(VW/16){16'h01FF}}, {(VW/16){16'h807F}}, '0, '0, 1'b0, 1'b0, 2'd3);
    // R9: gap then valid again
    step("R9 R10 idle hold", 1'b0, rnd_vec(), rnd_vec(), rnd_vec(), '0, 1'b1, 1'b1, 2'd0);
    step("R9 R10 idle hold 2", 1'b0, fill(8'hFF), fill(8'h7F), rnd_vec(), '0, 1'b0, 1'b0, 2'd1);
    // widths x mask modes
    for (int ws = 0; ws < 4; ws++) begin
      step("R5 R4 width clamp", 1'b1, fill(8'hFF), fill(8'h7F), rnd_vec(), '1, 1'b0, 1'b0, 2'(ws));
      step("R5 R3 width clamp low", 1'b1, fill(8'hFF), fill(8'h80), rnd_vec(), $urandom, 1'b1, 1'b0, 2'(ws));
      for (int md = 0; md < 3; md++) begin
        for (int k = 0; k < 4; k++) begin
          string t;
          t = (md == 0) ? "R6 R1 mask off" : (md == 1) ? "R7 R1 merge" : "R8 R1 zeroing";
          step(t, 1'b1, rnd_vec(), rnd_vec(), rnd_vec(), $urandom, md != 0, md == 2, 2'(ws));
        end
        step("R10 hold after mode", 1'b0, rnd_vec(), rnd_vec(), rnd_vec(), $urandom, 1'b1, 1'b1, 2'(3 - ws));
      end
    end
    // R7 merge with clamping lanes: flags stay set though word merged
    step("R7 R4 merge over clamp", 1'b1, fill(8'hFF), fill(8'h7F), rnd_vec(), 32'h0F0F_0F0F, 1'b1, 1'b0, 2'd3);
    step("R8 R4 zero over clamp", 1'b1, fill(8'hFF), fill(8'h80), rnd_vec(), 32'hA5A5_5A5A, 1'b1, 1'b1, 2'd2);
    for (int k = 0; k < 40; k++)
      step("R1 R2 R9 random", 1'($urandom % 4 != 0), rnd_vec(), rnd_vec(), rnd_vec(), $urandom,
           1'($urandom), 1'($urandom), 2'($urandom));
    step("R9 final drop", 1'b0, '0, '0, '0, '0, 1'b0, 1'b0, 2'd0);
    @(negedge clk);
    compare(pend);
    finish_run();
  end
endmodule